// File: doc/BRIEF.md
# Buffered Stream Fan-Out

This block takes one AXI4-Stream input and delivers every beat it accepts (payload, TLAST and TUSER together) to a build-time number of output streams. Input and outputs share one clock. Each output that honours TREADY owns a small synchronous FIFO (a depth of one gives a single-entry shim), so a slow consumer soaks up its own backpressure without disturbing its neighbours until its buffer fills. An output built without TREADY gets a plain register stage that presents each accepted beat for exactly one cycle.

A build-time policy decides what happens when a buffer fills. In stall mode the input TREADY drops while any ready-honouring buffer is full, so every output sees the same beat sequence. In drop mode the input never stalls. A beat that meets a full buffer is lost for that output alone, and a saturating per-output counter records each such loss. If no output honours TREADY, or the input is built without TREADY, the block behaves as in drop mode.

Top module: `stream_fanout`

## Requirements
- R1: In stall mode, every output delivers exactly the sequence of accepted input beats {TUSER, TLAST, data}, in order, with none lost or repeated.
- R2: An output that honours TREADY asserts TVALID exactly when its buffer holds at least one beat, and a buffer of depth DEPTH absorbs DEPTH beats while its TREADY is low.
- R3: In stall mode, once reset has been released, input TREADY is high exactly when no ready-honouring buffer is full, and the drop counters stay at zero.
- R4: In drop mode, input TREADY stays high from the first cycle after reset. A beat accepted while an output's buffer is full is left out of that output's stream only, and the other outputs still receive it.
- R5: Each output's drop counter (CNT_W bits, at bits [i*CNT_W +: CNT_W]) increments once for each beat it discards and saturates at 2^CNT_W-1.
- R6: An output built without TREADY shows each accepted beat on the cycle after acceptance, for exactly one cycle, whatever its TREADY input does.
- R7: When no output honours TREADY, the stall setting has no effect: the input TREADY stays high after reset and every accepted beat reaches every output one cycle later.
- R8: While reset is asserted, input TREADY and every output TVALID are low and every drop counter is zero. Input TREADY can first be high in the cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input TVALID |
| s_ready | output | 1 | Input TREADY |
| s_data | input | DATA_W | Input payload |
| s_last | input | 1 | Input TLAST |
| s_user | input | USER_W | Input TUSER |
| m_valid | output | N_OUT | Per-output TVALID, bit i for output i |
| m_ready | input | N_OUT | Per-output TREADY (ignored where not honoured) |
| m_data | output | N_OUT*DATA_W | Output payloads, output i at [i*DATA_W +: DATA_W] |
| m_last | output | N_OUT | Per-output TLAST |
| m_user | output | N_OUT*USER_W | Output TUSER, output i at [i*USER_W +: USER_W] |
| drop_cnt | output | N_OUT*CNT_W | Saturating discard counters, output i at [i*CNT_W +: CNT_W] |

## Verification
Three builds are driven with the same stimulus: stall mode with three FIFO outputs, drop mode with two shallow FIFO outputs and one register output, and stall mode with only register outputs. The stimulus sweeps all eight TREADY combinations, uses sparse input valid patterns, and then holds one output and later all outputs stalled for long runs. Together these show whether stalls are global or local, whether losses stay confined to the full output and whether the counter saturates, and whether the register outputs ignore backpressure. A bench model of each buffer predicts TVALID, beat content, input TREADY and the counter values on every cycle.

// File: rtl/fanout_pkg.sv
package fanout_pkg;
  // Width of a buffer pointer; at least one bit even for a single-entry shim.
  function automatic int ptr_w(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/fanout_fifo.sv
module fanout_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         not_empty,
  output logic         full
);
  localparam int PW = fanout_pkg::ptr_w(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign not_empty = (cnt_q != '0);
  assign full      = (cnt_q == CW'(DEPTH));
  assign do_push   = push && !full;
  assign do_pop    = pop && not_empty;
  assign rdata     = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end
endmodule

// File: rtl/fanout_reg.sv
module fanout_reg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         valid,
  output logic [W-1:0] dout
);
  logic         vld_q, vld_d;
  logic [W-1:0] dat_q;

  assign vld_d = load;
  assign valid = vld_q;
  assign dout  = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) dat_q <= din;
  end
endmodule

// File: rtl/fanout_sat_cnt.sv
module fanout_sat_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] count
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && (cnt_q != '1)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/stream_fanout.sv
module stream_fanout #(
  parameter int                N_OUT        = 3,
  parameter int                DATA_W       = 8,
  parameter int                USER_W       = 1,
  parameter int                DEPTH        = 4,
  parameter int                CNT_W        = 8,
  parameter bit                STALL_MODE   = 1'b1,
  parameter bit                IN_READY_EN  = 1'b1,
  parameter logic [N_OUT-1:0]  OUT_READY_EN = '1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [DATA_W-1:0]       s_data,
  input  logic                    s_last,
  input  logic [USER_W-1:0]       s_user,
  output logic [N_OUT-1:0]        m_valid,
  input  logic [N_OUT-1:0]        m_ready,
  output logic [N_OUT*DATA_W-1:0] m_data,
  output logic [N_OUT-1:0]        m_last,
  output logic [N_OUT*USER_W-1:0] m_user,
  output logic [N_OUT*CNT_W-1:0]  drop_cnt
);
  localparam int BW        = USER_W + 1 + DATA_W;
  localparam bit STALL_EFF = STALL_MODE && IN_READY_EN && (|OUT_READY_EN);

  logic          live_q, live_d;
  logic [BW-1:0] beat_in;
  logic [N_OUT-1:0] buf_full;
  logic [N_OUT-1:0] buf_push;
  logic [N_OUT-1:0] buf_drop;
  logic          hold;
  logic          accept;

  assign beat_in = {s_user, s_last, s_data};
  assign live_d  = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= live_d;
  end

  assign hold    = STALL_EFF && (|buf_full);
  assign s_ready = live_q && !hold;
  assign accept  = s_valid && s_ready;

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    logic [BW-1:0] beat_out;

    assign buf_push[i] = accept && !buf_full[i];
    assign buf_drop[i] = accept && buf_full[i];

    if (OUT_READY_EN[i]) begin : g_fifo
      fanout_fifo #(.W(BW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (buf_push[i]),
        .pop       (m_ready[i]),
        .wdata     (beat_in),
        .rdata     (beat_out),
        .not_empty (m_valid[i]),
        .full      (buf_full[i])
      );
    end else begin : g_reg
      logic unused_rdy;
      assign unused_rdy  = m_ready[i];
      assign buf_full[i] = 1'b0;
      fanout_reg #(.W(BW)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (buf_push[i]),
        .din   (beat_in),
        .valid (m_valid[i]),
        .dout  (beat_out)
      );
    end

    assign m_data[i*DATA_W +: DATA_W] = beat_out[DATA_W-1:0];
    assign m_last[i]                  = beat_out[DATA_W];
    assign m_user[i*USER_W +: USER_W] = beat_out[BW-1 -: USER_W];

    fanout_sat_cnt #(.CW(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (buf_drop[i]),
      .count (drop_cnt[i*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/fanout_checker.sv
module fanout_checker #(
  parameter int               N_OUT        = 3,
  parameter int               CNT_W        = 8,
  parameter bit               STALL_MODE   = 1'b1,
  parameter bit               IN_READY_EN  = 1'b1,
  parameter logic [N_OUT-1:0] OUT_READY_EN = '1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   s_valid,
  input logic                   s_ready,
  input logic [N_OUT-1:0]       m_valid,
  input logic [N_OUT*CNT_W-1:0] drop_cnt
);
  localparam bit STALL_EFF = STALL_MODE && IN_READY_EN && (|OUT_READY_EN);

  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R8: assert (!s_ready && (m_valid == '0) && (drop_cnt == '0));
    end
  end

  if (!STALL_EFF) begin : g_drop
    assert_never_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> s_ready);
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_each
    assert_cnt_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
      drop_cnt[i*CNT_W +: CNT_W] >= $past(drop_cnt[i*CNT_W +: CNT_W]));

    if (STALL_EFF) begin : g_stall
      assert_no_loss_in_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(drop_cnt[i*CNT_W +: CNT_W]));
      if (OUT_READY_EN[i]) begin : g_fifo
        assert_valid_after_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
          (s_valid && s_ready) |=> m_valid[i]);
      end
    end

    if (!OUT_READY_EN[i]) begin : g_reg
      assert_reg_follows_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> m_valid[i]);
      assert_reg_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_valid && s_ready) |=> !m_valid[i]);
    end
  end
endmodule

bind stream_fanout fanout_checker #(
  .N_OUT        (N_OUT),
  .CNT_W        (CNT_W),
  .STALL_MODE   (STALL_MODE),
  .IN_READY_EN  (IN_READY_EN),
  .OUT_READY_EN (OUT_READY_EN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .m_valid  (m_valid),
  .drop_cnt (drop_cnt)
);

// File: tb/sim_stream_fanout.sv
`timescale 1ns/1ps
module sim_stream_fanout;
  localparam int D0 = 4;
  localparam int D1 = 2;
  localparam int CMAX1 = 7;

  logic clk;
  logic rst_n;
  logic s_valid;
  logic [7:0] s_data;
  logic s_last;
  logic s_user;
  logic [2:0] m_ready;

  logic r0; logic [2:0] v0; logic [23:0] d0; logic [2:0] l0; logic [2:0] us0; logic [23:0] dc0;
  logic r1; logic [2:0] v1; logic [23:0] d1; logic [2:0] l1; logic [2:0] us1; logic [8:0]  dc1;
  logic r2; logic [1:0] v2; logic [15:0] d2; logic [1:0] l2; logic [1:0] us2; logic [15:0] dc2;

  stream_fanout #(.N_OUT(3), .DEPTH(D0), .STALL_MODE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(r0), .s_data(s_data),
    .s_last(s_last), .s_user(s_user), .m_valid(v0), .m_ready(m_ready), .m_data(d0),
    .m_last(l0), .m_user(us0), .drop_cnt(dc0));

  stream_fanout #(.N_OUT(3), .DEPTH(D1), .CNT_W(3), .STALL_MODE(1'b0),
                  .OUT_READY_EN(3'b011)) u1 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(r1), .s_data(s_data),
    .s_last(s_last), .s_user(s_user), .m_valid(v1), .m_ready(m_ready), .m_data(d1),
    .m_last(l1), .m_user(us1), .drop_cnt(dc1));

  stream_fanout #(.N_OUT(2), .DEPTH(D0), .STALL_MODE(1'b1),
                  .OUT_READY_EN(2'b00)) u2 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(r2), .s_data(s_data),
    .s_last(s_last), .s_user(s_user), .m_valid(v2), .m_ready(m_ready[1:0]), .m_data(d2),
    .m_last(l2), .m_user(us2), .drop_cnt(dc2));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench-side models of the buffers
  int         occ0 [3];
  logic [9:0] mq0  [3][8];
  int         occ1 [3];
  logic [9:0] mq1  [3][8];
  int         cnt1 [3];
  bit         started;
  bit         rv1, rv2;
  logic [9:0] rd1, rd2;
  bit         exp_r0;

  task automatic check_all();
    logic [9:0] b;
    exp_r0 = started;
    for (int i = 0; i < 3; i++) if (occ0[i] >= D0) exp_r0 = 0;
    chk(r0 == exp_r0, started ? "R3" : "R8", int'(r0), int'(exp_r0));
    for (int i = 0; i < 3; i++) begin
      chk(v0[i] == (occ0[i] > 0), "R2", int'(v0[i]), int'(occ0[i] > 0));
      b = {us0[i], l0[i], d0[i*8 +: 8]};
      if (occ0[i] > 0) chk(b == mq0[i][0], "R1", int'(b), int'(mq0[i][0]));
      chk(dc0[i*8 +: 8] == 8'd0, "R3", int'(dc0[i*8 +: 8]), 0);
    end
    chk(r1 == started, started ? "R4" : "R8", int'(r1), int'(started));
    for (int i = 0; i < 2; i++) begin
      chk(v1[i] == (occ1[i] > 0), "R2", int'(v1[i]), int'(occ1[i] > 0));
      b = {us1[i], l1[i], d1[i*8 +: 8]};
      if (occ1[i] > 0) chk(b == mq1[i][0], "R4", int'(b), int'(mq1[i][0]));
      chk(dc1[i*3 +: 3] == 3'(cnt1[i]), "R5", int'(dc1[i*3 +: 3]), cnt1[i]);
    end
    chk(v1[2] == rv1, "R6", int'(v1[2]), int'(rv1));
    b = {us1[2], l1[2], d1[16 +: 8]};
    if (rv1) chk(b == rd1, "R6", int'(b), int'(rd1));
    chk(r2 == started, started ? "R7" : "R8", int'(r2), int'(started));
    for (int i = 0; i < 2; i++) begin
      chk(v2[i] == rv2, "R7", int'(v2[i]), int'(rv2));
      b = {us2[i], l2[i], d2[i*8 +: 8]};
      if (rv2) chk(b == rd2, "R7", int'(b), int'(rd2));
    end
  endtask

  task automatic drive(input int cyc);
    s_data = 8'(cyc * 3 + 1);
    s_last = (cyc % 5) == 4;
    s_user = (cyc % 7) == 0;
    if (cyc < 60) begin
      s_valid = 1'b1; m_ready = 3'b111;
    end else if (cyc < 220) begin
      s_valid = 1'b1; m_ready = 3'((cyc / 5) % 8);
    end else if (cyc < 340) begin
      s_valid = ((cyc * 7) % 3) != 0; m_ready = 3'((cyc * 5 / 3) % 8);
    end else if (cyc < 400) begin
      s_valid = 1'b1; m_ready = 3'b110;
    end else if (cyc < 450) begin
      s_valid = 1'b1; m_ready = 3'b000;
    end else if (cyc < 520) begin
      s_valid = 1'b0; m_ready = 3'b111;
    end else begin
      s_valid = (cyc % 2) == 0; m_ready = 3'b101;
    end
  endtask

  // Advance the models to the state after the coming rising edge
  task automatic update();
    logic [9:0] b;
    bit acc, full, pop;
    b = {s_user, s_last, s_data};
    acc = s_valid && exp_r0;
    for (int i = 0; i < 3; i++) begin
      pop = (occ0[i] > 0) && m_ready[i];
      if (pop) begin
        for (int k = 0; k < 7; k++) mq0[i][k] = mq0[i][k+1];
        occ0[i]--;
      end
      if (acc) begin mq0[i][occ0[i]] = b; occ0[i]++; end
    end
    acc = s_valid && started;
    for (int i = 0; i < 2; i++) begin
      full = occ1[i] == D1;
      pop  = (occ1[i] > 0) && m_ready[i];
      if (pop) begin
        for (int k = 0; k < 7; k++) mq1[i][k] = mq1[i][k+1];
        occ1[i]--;
      end
      if (acc) begin
        if (full) begin
          if (cnt1[i] < CMAX1) cnt1[i]++;
        end else begin
          mq1[i][occ1[i]] = b; occ1[i]++;
        end
      end
    end
    rv1 = acc; if (acc) rd1 = b;
    rv2 = acc; if (acc) rd2 = b;
    started = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; s_valid = 1'b0; s_data = '0; s_last = 0; s_user = 0; m_ready = '0;
    started = 0; rv1 = 0; rv2 = 0; rd1 = '0; rd2 = '0;
    for (int i = 0; i < 3; i++) begin occ0[i] = 0; occ1[i] = 0; cnt1[i] = 0; end
    repeat (3) @(negedge clk);
    // R8: quiet state while reset is held
    chk(!r0 && !r1 && !r2, "R8", int'({r0, r1, r2}), 0);
    chk(v0 == 0 && v1 == 0 && v2 == 0, "R8", int'({v0, v1, v2}), 0);
    chk(dc0 == 0 && dc1 == 0 && dc2 == 0, "R8", int'(dc1), 0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 600; cyc++) begin
      check_all();
      drive(cyc);
      update();
      @(negedge clk);
    end
    check_all();
    // R5: the long stall of output 0 must have saturated its counter
    chk(dc1[2:0] == 3'd7, "R5", int'(dc1[2:0]), 7);
    finish_run();
  end
endmodule